// File: doc/BRIEF.md
# Peripheral configuration access filter

This block guards the configuration port of one peripheral. Every transfer that arrives on the upstream side carries three attributes: secure, privileged and instruction fetch. The block compares these attributes with two configuration bits that belong to the peripheral. The first bit, `sec_cfg`, demands secure access. The second bit, `priv_cfg`, demands privileged access. A transfer that satisfies both demands and is a data access goes through to the peripheral unchanged, in the same cycle. Any other transfer is stopped at the filter.

A stopped transfer never reaches the peripheral. The upstream side gets an error response, and a stopped read returns all-zero data. One clock later the block raises a single-cycle event pulse, tagged with the peripheral's fixed index (below 128), toward an interrupt collector. The configuration bits are produced elsewhere, and the collector that records events is outside this block.

Transfers are single-cycle. The peripheral answers reads combinationally, and the response is returned in the cycle in which the request is presented.

Top module: `cfg_access_filter`

## Requirements
- R1: A valid transfer with `req_fetch`=1 is answered with `rsp_error`=1 and is not forwarded (`per_valid`=0), whatever `sec_cfg` and `priv_cfg` hold.
- R2: With `sec_cfg`=1, a valid data transfer with `req_secure`=0 is blocked (`rsp_error`=1). A transfer with `req_secure`=1 is not blocked by this check.
- R3: With `priv_cfg`=1, a valid data transfer with `req_priv`=0 is blocked (`rsp_error`=1). A transfer with `req_priv`=1 is not blocked by this check.
- R4: A valid data transfer passes only when it meets both checks at once. In that case `per_valid`=1 and `rsp_error`=0 in the same cycle.
- R5: A passing transfer reaches the peripheral with `per_write`, `per_addr` and `per_wdata` equal to the request, and `rsp_rdata` equals `per_rdata`. With `req_valid`=0, `rsp_error` and `per_valid` are both 0.
- R6: A blocked transfer, read or write, keeps `per_valid` and `per_write` at 0. A blocked transfer returns `rsp_rdata`=0 together with `rsp_error`=1.
- R7: For each blocked transfer, `evt_pulse` is 1 in exactly the following cycle, with `evt_index`=`PERIPH_IDX`. `evt_pulse` is 0 in the cycle after any cycle that has no blocked transfer.
- R8: During reset `evt_pulse` is 0. With `sec_cfg`=`priv_cfg`=0, as after reset, every data transfer passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_cfg | input | 1 | 1: only secure data accesses are allowed |
| priv_cfg | input | 1 | 1: only privileged data accesses are allowed |
| req_valid | input | 1 | Transfer present this cycle |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_secure | input | 1 | Transfer is secure |
| req_priv | input | 1 | Transfer is privileged |
| req_fetch | input | 1 | Transfer is an instruction fetch |
| rsp_rdata | output | DW | Read data returned upstream |
| rsp_error | output | 1 | Error response for a blocked transfer |
| per_valid | output | 1 | Transfer forwarded to the peripheral |
| per_write | output | 1 | Forwarded write strobe |
| per_addr | output | AW | Forwarded address |
| per_wdata | output | DW | Forwarded write data |
| per_rdata | input | DW | Peripheral read data |
| evt_pulse | output | 1 | One-cycle illegal-access event |
| evt_index | output | IDX_W | Peripheral index carried by the event |

## Verification
Almost all of the block is combinational, so a wrong decision shows up at the ports in the same cycle as the request. It appears either as an error on a legal access or as `per_valid` raised for an illegal one. The event flop is the only stored state. If it is wrong, the error appears one cycle late, as a missing pulse, an extra pulse, or a pulse that lasts two cycles. Sweeping every combination of configuration bits, attributes and direction, with an idle cycle after each transfer, exposes each of these faults within two cycles of the transfer that triggers it.

// File: rtl/cfg_access_filter.sv
module cfg_access_filter #(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int IDX_W      = 7,
  parameter int PERIPH_IDX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_cfg,
  input  logic             priv_cfg,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_secure,
  input  logic             req_priv,
  input  logic             req_fetch,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_error,
  output logic             per_valid,
  output logic             per_write,
  output logic [AW-1:0]    per_addr,
  output logic [DW-1:0]    per_wdata,
  input  logic [DW-1:0]    per_rdata,
  output logic             evt_pulse,
  output logic [IDX_W-1:0] evt_index
);
  localparam logic [IDX_W-1:0] IDX_VAL = IDX_W'(PERIPH_IDX);

  logic sec_ok, priv_ok, legal, blocked;

  assign sec_ok  = req_secure | ~sec_cfg;
  assign priv_ok = req_priv | ~priv_cfg;
  assign legal   = sec_ok & priv_ok & ~req_fetch;
  assign blocked = req_valid & ~legal;

  assign per_valid = req_valid & legal;
  assign per_write = per_valid & req_write;
  assign per_addr  = req_addr;
  assign per_wdata = req_wdata;

  assign rsp_error = blocked;
  assign rsp_rdata = blocked ? '0 : per_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_pulse <= 1'b0;
    else        evt_pulse <= blocked;
  end

  assign evt_index = IDX_VAL;
endmodule

// File: rtl/cfg_access_filter_chk.sv
module cfg_access_filter_chk #(
  parameter int DW         = 32,
  parameter int IDX_W      = 7,
  parameter int PERIPH_IDX = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_cfg,
  input logic             priv_cfg,
  input logic             req_valid,
  input logic             req_secure,
  input logic             req_priv,
  input logic             req_fetch,
  input logic [DW-1:0]    rsp_rdata,
  input logic             rsp_error,
  input logic             per_valid,
  input logic             per_write,
  input logic             evt_pulse,
  input logic [IDX_W-1:0] evt_index
);
  // R1
  fetch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_fetch |-> rsp_error && !per_valid);
  // R2
  sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && sec_cfg && !req_secure |-> rsp_error);
  // R3
  priv_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && priv_cfg && !req_priv |-> rsp_error);
  // R4
  legal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_fetch && (req_secure || !sec_cfg) && (req_priv || !priv_cfg)
    |-> per_valid && !rsp_error);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !rsp_error && !per_valid);
  // R6
  blocked_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> !per_valid && !per_write && rsp_rdata == '0);
  // R7
  evt_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |=> evt_pulse && evt_index == IDX_W'(PERIPH_IDX));
  // R7
  evt_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_error |=> !evt_pulse);
  // R8
  always @(negedge clk)
    if (!rst_n) evt_reset_chk: assert (!evt_pulse);
endmodule

bind cfg_access_filter cfg_access_filter_chk #(
  .DW(DW), .IDX_W(IDX_W), .PERIPH_IDX(PERIPH_IDX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sec_cfg(sec_cfg), .priv_cfg(priv_cfg),
  .req_valid(req_valid), .req_secure(req_secure), .req_priv(req_priv),
  .req_fetch(req_fetch), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
  .per_valid(per_valid), .per_write(per_write), .evt_pulse(evt_pulse),
  .evt_index(evt_index)
);

// File: tb/cfg_access_filter_tb.sv
`timescale 1ns/100ps
module cfg_access_filter_tb_top;
  localparam int AW = 12, DW = 32, IDX_W = 7, PIDX = 93;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sec_cfg = 0, priv_cfg = 0;
  logic req_valid = 0, req_write = 0, req_secure = 0, req_priv = 0, req_fetch = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata, per_wdata, per_rdata;
  logic rsp_error, per_valid, per_write, evt_pulse;
  logic [AW-1:0] per_addr;
  logic [IDX_W-1:0] evt_index;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign per_rdata = {20'hC0FFE, per_addr};

  cfg_access_filter #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .PERIPH_IDX(PIDX)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_cfg(sec_cfg), .priv_cfg(priv_cfg),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_secure(req_secure), .req_priv(req_priv),
    .req_fetch(req_fetch), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
    .per_valid(per_valid), .per_write(per_write), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rdata), .evt_pulse(evt_pulse),
    .evt_index(evt_index)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit s_cfg, input bit p_cfg, input bit sec, input bit prv,
                      input bit fet, input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit blk;
    blk = fet || (s_cfg && !sec) || (p_cfg && !prv);
    sec_cfg = s_cfg; priv_cfg = p_cfg;
    req_valid = 1; req_secure = sec; req_priv = prv; req_fetch = fet;
    req_write = wr; req_addr = a; req_wdata = d;
    #1;
    if (fet) check("R1 fetch error", {rsp_error, per_valid}, 2'b10);
    else if (s_cfg && !sec) check("R2 sec block", rsp_error, 1'b1);
    else if (p_cfg && !prv) check("R3 priv block", rsp_error, 1'b1);
    else check("R4 pass", {per_valid, rsp_error}, 2'b10);
    if (blk) begin
      check("R6 blocked hidden", {per_valid, per_write}, 2'b00);
      check("R6 blocked rdata", rsp_rdata, '0);
    end else begin
      check("R5 fwd fields", {per_write, per_addr, per_wdata}, {wr, a, d});
      check("R5 fwd rdata", rsp_rdata, {20'hC0FFE, a});
    end
    @(negedge clk);
    req_valid = 0;
    check("R7 event", {evt_pulse, evt_pulse ? evt_index : 7'd0}, {blk, blk ? 7'(PIDX) : 7'd0});
    #1;
    check("R5 idle", {rsp_error, per_valid}, 2'b00);
    @(negedge clk);
    check("R7 single pulse", evt_pulse, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req_valid = 1; req_fetch = 1;
    @(negedge clk);
    check("R8 no evt in reset", evt_pulse, 1'b0);
    req_valid = 0; req_fetch = 0;
    rst_n = 1;
    @(negedge clk);
    for (int v = 0; v < 8; v++)
      xfer(0, 0, v[0], v[1], 0, v[2], AW'(16 * v + 3), 32'h1234_0000 + v);
    for (int v = 0; v < 64; v++)
      xfer(v[5], v[4], v[3], v[2], v[1], v[0], AW'(v * 37), 32'hA5A5_0000 ^ (v * 32'h0101));
    xfer(1, 1, 0, 0, 0, 0, 12'hFFF, '1);
    xfer(1, 1, 0, 0, 0, 1, 12'h000, '1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule